// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Line-Break Handling

This block turns an asynchronous serial line into bytes. It does not divide a clock itself. An outside rate generator gives it a one-cycle enable, the base tick, at either sixteen or eight times the bit rate. The `lo_mode` input chooses the ratio. The line passes through a two-flop synchronizer. The block detects a high-to-low transition on the base tick and aligns its bit counter to that transition. It then samples the start bit, eight data bits (least significant first), an optional parity bit and one stop bit, each near the middle of the bit.

A frame that is clean gives a one-cycle write strobe with the byte, for a receive FIFO. A low stop bit gives a framing-error pulse. A parity mismatch gives a parity-error pulse. The block enters a break condition when a frame reads entirely low, stop bit included. While in break it keeps framing characters on the low line and keeps flagging their errors, but it writes nothing to the FIFO. It leaves break as soon as the line is seen high on a base tick. The synchronized line level is brought out so that software can confirm a break after a framing error.

Top module: `uart_os_rx`

## Requirements
- R1: Out of reset, `push_o`, `frame_err_o`, `parity_err_o` and `in_break_o` are low and `line_level_o` is high.
- R2: With `lo_mode`=0 (sixteen ticks per bit), a well-formed frame gives exactly one `push_o` pulse. `push_data_o` carries the eight data bits, and the first data bit on the line is bit 0.
- R3: With `lo_mode`=1 (eight ticks per bit), frames are received in the same way as in R2.
- R4: With `par_en`=1, a parity bit follows the data. `par_odd`=0 requires an even count of ones over data plus parity, and `par_odd`=1 requires an odd count. A mismatch gives one `parity_err_o` pulse and no `push_o`. With `par_en`=0, no parity bit is expected.
- R5: A stop bit read low gives one `frame_err_o` pulse and no `push_o`. Outside a break, the receiver then waits for the line to go high before it accepts a new start bit.
- R6: A start bit that reads high at its mid-bit sample (after half a bit time: 8 ticks in 16x mode, 4 in 8x mode) is discarded. It gives no push and no error flag.
- R7: A frame whose sampled bits are all low, stop bit included, sets `in_break_o` in the same cycle as its `frame_err_o` pulse. While `in_break_o` is high, `push_o` stays low, but frames keep restarting on the low line and keep raising `frame_err_o`. `parity_err_o` is also raised when odd parity is selected.
- R8: `in_break_o` clears on the first base tick that sees the line high. Frames received after that are pushed again.
- R9: `line_level_o` equals `rx_in` delayed by two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Oversampling enable, one cycle wide |
| lo_mode | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rx_in | input | 1 | Asynchronous serial line |
| push_o | output | 1 | FIFO write strobe for a clean byte |
| push_data_o | output | 8 | Received byte |
| frame_err_o | output | 1 | Stop bit read low (pulse) |
| parity_err_o | output | 1 | Parity mismatch (pulse) |
| in_break_o | output | 1 | Line-break condition active |
| line_level_o | output | 1 | Synchronized line level |

## Verification
The hardest situation to reach from the ports is the break. The receiver has to restart frames on a line that never rises, and then come out of break while a frame is still partly sampled. The stimulus holds the line low for about thirty bit times with odd parity selected. It checks that framing and parity errors keep arriving while nothing is pushed. It then releases the line in the middle of a frame and confirms that the next properly formed character is written again. Random frames mix both ratios, both parities, bad parity and bad stop bits, and short start glitches cover the false-start path.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;
endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // Line idles high, so reset to the mark level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_os_rx_timer.sv
module uart_os_rx_timer #(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  logic run,
  input  logic half,
  input  logic lo_mode,
  output logic sample
);
  localparam int CW = $clog2(OS_HI + 1);

  logic [CW-1:0] cnt, cnt_n, target;

  always_comb begin
    if (half) target = lo_mode ? CW'(OS_LO / 2) : CW'(OS_HI / 2);
    else      target = lo_mode ? CW'(OS_LO)     : CW'(OS_HI);
  end

  assign sample = run && tick && ((cnt + 1'b1) == target);

  always_comb begin
    cnt_n = cnt;
    if (clear)            cnt_n = CW'(1);   // detection tick counts as pulse one
    else if (run && tick) cnt_n = sample ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sample,
  input  logic          rx_s,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          start,
  output logic          run,
  output logic          half,
  output logic          push,
  output logic [DW-1:0] data,
  output logic          ferr,
  output logic          perr,
  output logic          brk
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] LAST = IW'(DW - 1);

  rx_state_t     st, st_n;
  logic [IW-1:0] idx, idx_n;
  logic [DW-1:0] sh_n;
  logic          acc, acc_n, ones, ones_n, armed, armed_n, brk_n;
  logic          push_n, ferr_n, perr_n;

  assign start = (st == ST_IDLE) && tick && armed && !rx_s;
  assign run   = (st != ST_IDLE);
  assign half  = (st == ST_START);

  always_comb begin
    st_n    = st;
    idx_n   = idx;
    sh_n    = data;
    acc_n   = acc;
    ones_n  = ones;
    armed_n = armed;
    brk_n   = brk;
    push_n  = 1'b0;
    ferr_n  = 1'b0;
    perr_n  = 1'b0;
    if (tick && rx_s) armed_n = 1'b1;
    if (tick && rx_s && brk) brk_n = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        st_n   = ST_START;
        idx_n  = '0;
        acc_n  = 1'b0;
        ones_n = 1'b0;
      end
      ST_START: if (sample) st_n = rx_s ? ST_IDLE : ST_DATA;
      ST_DATA: if (sample) begin
        sh_n   = {rx_s, data[DW-1:1]};
        acc_n  = acc ^ rx_s;
        ones_n = ones | rx_s;
        idx_n  = idx + 1'b1;
        if (idx == LAST) st_n = par_en ? ST_PAR : ST_STOP;
      end
      ST_PAR: if (sample) begin
        acc_n  = acc ^ rx_s;
        ones_n = ones | rx_s;
        st_n   = ST_STOP;
      end
      ST_STOP: if (sample) begin
        st_n   = ST_IDLE;
        ferr_n = !rx_s;
        perr_n = par_en && (acc != par_odd);
        if (!rx_s && ones)  armed_n = 1'b0;   // ordinary framing error: wait for mark
        if (!rx_s && !ones) brk_n   = 1'b1;   // all-low frame: line break
        push_n = rx_s && !perr_n && !brk;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      data  <= '0;
      acc   <= 1'b0;
      ones  <= 1'b0;
      armed <= 1'b0;
      brk   <= 1'b0;
      push  <= 1'b0;
      ferr  <= 1'b0;
      perr  <= 1'b0;
    end else begin
      st    <= st_n;
      idx   <= idx_n;
      data  <= sh_n;
      acc   <= acc_n;
      ones  <= ones_n;
      armed <= armed_n;
      brk   <= brk_n;
      push  <= push_n;
      ferr  <= ferr_n;
      perr  <= perr_n;
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DW    = 8,
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_tick,
  input  logic          lo_mode,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rx_in,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          frame_err_o,
  output logic          parity_err_o,
  output logic          in_break_o,
  output logic          line_level_o
);
  logic rx_s, start, run, half, sample;

  uart_os_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rx_s)
  );

  uart_os_rx_timer #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .clear(start), .run(run),
    .half(half), .lo_mode(lo_mode), .sample(sample)
  );

  uart_os_rx_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .sample(sample), .rx_s(rx_s),
    .par_en(par_en), .par_odd(par_odd), .start(start), .run(run), .half(half),
    .push(push_o), .data(push_data_o), .ferr(frame_err_o), .perr(parity_err_o),
    .brk(in_break_o)
  );

  assign line_level_o = rx_s;
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          par_en,
  input logic          rx_in,
  input logic          push_o,
  input logic [DW-1:0] push_data_o,
  input logic          frame_err_o,
  input logic          parity_err_o,
  input logic          in_break_o,
  input logic          line_level_o
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R4 R5
  push_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (!frame_err_o && !parity_err_o));

  // R4
  perr_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err_o |-> par_en);

  // R7
  push_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> !in_break_o);

  // R7
  brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_break_o) |-> frame_err_o);

  // R8
  brk_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_break_o) |-> $past(line_level_o));

  // R9
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (line_level_o == $past(rx_in, 2)));
endmodule

bind uart_os_rx uart_os_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_en(par_en), .rx_in(rx_in), .push_o(push_o),
  .push_data_o(push_data_o), .frame_err_o(frame_err_o),
  .parity_err_o(parity_err_o), .in_break_o(in_break_o),
  .line_level_o(line_level_o)
);

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;

  logic clk = 1'b0, rst_n = 1'b0, base_tick = 1'b0;
  logic lo_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0, rx_in = 1'b1;
  logic push_o, frame_err_o, parity_err_o, in_break_o, line_level_o;
  logic [7:0] push_data_o;

  int n_chk = 0, n_fail = 0, n_push = 0, n_ferr = 0, n_perr = 0;
  logic [7:0] last_data = '0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_os_rx u_uart_os_rx (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .lo_mode(lo_mode),
    .par_en(par_en), .par_odd(par_odd), .rx_in(rx_in), .push_o(push_o),
    .push_data_o(push_data_o), .frame_err_o(frame_err_o),
    .parity_err_o(parity_err_o), .in_break_o(in_break_o),
    .line_level_o(line_level_o)
  );

  initial begin
    forever begin
      repeat (DIV - 1) @(posedge clk) base_tick <= 1'b0;
      @(posedge clk) base_tick <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (push_o) begin n_push++; last_data = push_data_o; end
    if (frame_err_o) n_ferr++;
    if (parity_err_o) n_perr++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (lo_mode ? 8 : 16) * DIV;
  endfunction

  function automatic bit par_bit(input logic [7:0] d, input bit odd);
    return (^d) ^ odd;
  endfunction

  task automatic send_bit(input bit b);
    rx_in <= b;
    repeat (bit_clks()) @(posedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip, input bit stop_v);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (par_en) send_bit(par_bit(d, par_odd) ^ flip);
    send_bit(stop_v);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int p0, f0, e0, kind, seed;
    logic [7:0] d;
    seed = $urandom(32'd20240611);
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!push_o && !frame_err_o && !parity_err_o, "R1 flags", {push_o, frame_err_o, parity_err_o}, 0);
    chk(!in_break_o, "R1 break", in_break_o, 0);
    chk(line_level_o, "R1 level", line_level_o, 1);
    @(posedge clk) rst_n <= 1'b1;
    repeat (4 * 16 * DIV) @(posedge clk);

    // R2 R3 directed: both ratios, no parity
    for (int m = 0; m < 2; m++) begin
      lo_mode = m[0]; par_en = 0;
      p0 = n_push;
      send_frame(8'hA5, 0, 1);
      @(negedge clk);
      chk(n_push == p0 + 1 && last_data == 8'hA5, m ? "R3 directed" : "R2 directed", last_data, 8'hA5);
    end

    // R2 R3 R4 R5 random frames
    for (int k = 0; k < 48; k++) begin
      lo_mode = $urandom % 2; par_en = $urandom % 2; par_odd = $urandom % 2;
      d = 8'($urandom);
      kind = $urandom % 6;
      if (kind == 4 && !par_en) kind = 0;
      if (kind == 5 && d == 0) d = 8'h01;
      p0 = n_push; f0 = n_ferr; e0 = n_perr;
      send_frame(d, kind == 4, kind != 5);
      @(negedge clk);
      if (kind == 4) begin
        chk(n_perr == e0 + 1 && n_push == p0, "R4 parity error", n_perr - e0, 1);
      end else if (kind == 5) begin
        chk(n_ferr == f0 + 1 && n_push == p0, "R5 framing error", n_ferr - f0, 1);
      end else begin
        chk(n_push == p0 + 1 && last_data == d && n_ferr == f0 && n_perr == e0,
            lo_mode ? "R3 random frame" : "R2 random frame", last_data, d);
      end
    end

    // R6 glitch on start bit in both modes
    for (int m = 0; m < 2; m++) begin
      lo_mode = m[0]; par_en = 0;
      p0 = n_push; f0 = n_ferr; e0 = n_perr;
      rx_in <= 1'b0;
      repeat (2 * DIV) @(posedge clk);
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      @(negedge clk);
      chk(n_push == p0 && n_ferr == f0 && n_perr == e0, "R6 glitch ignored",
          n_push - p0 + n_ferr - f0, 0);
      p0 = n_push;
      send_frame(8'h3C, 0, 1);
      @(negedge clk);
      chk(n_push == p0 + 1 && last_data == 8'h3C, "R6 recovery", last_data, 8'h3C);
    end

    // R7 break with odd parity, R9 level
    lo_mode = 0; par_en = 1; par_odd = 1;
    p0 = n_push; f0 = n_ferr; e0 = n_perr;
    rx_in <= 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(line_level_o == 1'b0, "R9 level low", line_level_o, 0);
    repeat (30 * bit_clks()) @(posedge clk);
    @(negedge clk);
    chk(in_break_o, "R7 break set", in_break_o, 1);
    chk(n_push == p0, "R7 no push in break", n_push - p0, 0);
    chk(n_ferr >= f0 + 2, "R7 framing continues", n_ferr - f0, 2);
    chk(n_perr >= e0 + 1, "R7 parity in break", n_perr - e0, 1);
    // R8 exit
    rx_in <= 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(line_level_o == 1'b1, "R9 level high", line_level_o, 1);
    repeat (25 * bit_clks()) @(posedge clk);
    @(negedge clk);
    chk(!in_break_o, "R8 break cleared", in_break_o, 0);
    p0 = n_push;
    send_frame(8'h96, 0, 1);
    @(negedge clk);
    chk(n_push == p0 + 1 && last_data == 8'h96, "R8 push resumes", last_data, 8'h96);
    finish_run();
  end
endmodule